// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns read requests on a memory-mapped window into complete serial flash read sequences. Each chip select has its own setup word. The setup word names the read opcode, the number of address bytes (1 to 4), the number of dummy bytes (0 to 3) and the data lane width: one, two or four lines. An ownership switch decides which source drives the SPI pins. When the switch is 1, this read path owns the pins. When it is 0, a separate command engine owns them and its pin signals pass straight through.

For a request on `rd_cs` at address `rd_addr` for `rd_len` bytes, the engine does the following:
- It lowers the selected chip select.
- It sends the opcode and then the low address bytes, most significant bit first, on IO0.
- It clocks eight SCLK periods for each dummy byte.
- It shifts in the data at the configured lane width.
- It raises the chip select and returns the bytes in `rd_data` with a one-cycle `rd_valid` pulse.

SCLK runs at half the system clock in SPI mode 0: it idles low, the flash samples on the rising edge, and the engine captures on the falling edge.

The sequencer has eight states:
- `ST_IDLE` waits for a request.
- `ST_REFUSE` is a one-cycle error answer. Its transition is IDLE→REFUSE→IDLE.
- `ST_SELECT` holds the chip select low for one clock before the first edge.
- `ST_OPCODE` shifts out 8 bits, then goes to ADDRESS.
- `ST_ADDRESS` shifts out 8×address-bytes bits, then goes to DUMMY if the dummy count is non-zero, otherwise to DATA.
- `ST_DUMMY` runs for 8×dummy SCLK periods, then goes to DATA.
- `ST_DATA` runs for 8×len/width SCLK periods, then goes to RELEASE.
- `ST_RELEASE` deasserts the chip select, pulses `rd_valid` and returns to IDLE.

Top module: `flash_window_reader`

## Requirements
- R1: A configuration write to word n (0 ≤ n < NUM_CS) sets the setup of chip select n from `cfg_wdata`. The fields are: opcode in bits 7:0, address bytes minus one in bits 9:8, dummy bytes in bits 11:10, and lane mode in bits 13:12. A write to word NUM_CS sets the ownership switch from bit 0.
- R2: With the switch at 0, `spi_sclk`, `spi_cs_n`, `spi_io_out` and `spi_io_oe` equal the `cmd_*` inputs. With the switch at 1, the read path drives them, and when idle it shows SCLK low, all chip selects high and no output enables.
- R3: A request is refused with a one-cycle `rd_err` pulse, one clock after it is taken, and with no chip select activity, in either of these cases: the switch is 0, or `rd_len` is 0 or greater than MAX_BYTES.
- R4: An accepted request lowers only the addressed chip select. The opcode is sent MSB-first on `spi_io_out[0]` with output enable 4'b0001. SCLK has a period of two clocks and a high phase of one clock.
- R5: Each dummy byte takes 8 SCLK periods. During the dummy and data phases no pin is output-enabled. The total number of SCLK rising edges is 8 + 8·address bytes + 8·dummy bytes + 8·len/width.
- R6: Lane mode 0 reads one bit per SCLK on IO1. Mode 1 reads two bits, IO1 carrying the earlier bit. Mode 3 reads four bits, IO3 carrying the earliest bit. Mode 2 behaves as mode 0.
- R7: The first received byte appears in `rd_data[7:0]`, received byte k in `rd_data[8k+7:8k]`, and bytes at and above `rd_len` read zero.
- R8: `rd_busy` rises the clock after a request is taken. `rd_valid` pulses for one cycle while all chip selects are already high. `rd_busy` is low the cycle after `rd_valid`.
- R9: A request raised while `rd_busy` is high is ignored, and the read in flight completes unchanged.
- R10: Only the low address-bytes bytes of `rd_addr` are sent, the most significant of them first. Higher address bits are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Word index: setups 0..NUM_CS-1, switch at NUM_CS |
| cfg_wdata | input | 14 | Configuration write data |
| rd_req | input | 1 | Read request, one cycle |
| rd_cs | input | CS_W | Chip select of the request |
| rd_addr | input | 32 | Flash byte address |
| rd_len | input | LEN_W | Byte count, 1..MAX_BYTES |
| rd_busy | output | 1 | Read in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_err | output | 1 | Request refused pulse |
| rd_data | output | 8·MAX_BYTES | Returned bytes |
| cmd_sclk | input | 1 | Command engine clock pin |
| cmd_cs_n | input | NUM_CS | Command engine chip selects |
| cmd_io_out | input | 4 | Command engine data out |
| cmd_io_oe | input | 4 | Command engine output enables |
| spi_sclk | output | 1 | SPI clock pin |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_out | output | 4 | Data lines out |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_in | input | 4 | Data lines in |

## Verification
The bound checker watches the following properties on every clock:
- At most one chip select is low.
- No chip select or SCLK activity occurs while idle.
- SCLK high phases last one clock.
- `rd_err` only follows a request and never coincides with `rd_valid`.
- `rd_busy` falls right after `rd_valid`.

Some behaviours can only be shown by the bench's flash model and scenarios. These are the bit order of opcode and address on the wire, the dummy length, lane assembly in each mode, byte placement in `rd_data`, refusal conditions, pin hand-over, and the ignoring of requests during a read.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

    localparam int SETUP_W = 14;

    typedef enum logic [1:0] {
        LANES_1   = 2'd0,
        LANES_2   = 2'd1,
        LANES_RSV = 2'd2,
        LANES_4   = 2'd3
    } lane_mode_e;

    // Packed so that bit positions match the configuration word.
    typedef struct packed {
        lane_mode_e  mode;     // 13:12
        logic [1:0]  dummy;    // 11:10
        logic [1:0]  addr_m1;  // 9:8
        logic [7:0]  opcode;   // 7:0
    } setup_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFUSE,
        ST_SELECT,
        ST_OPCODE,
        ST_ADDRESS,
        ST_DUMMY,
        ST_DATA,
        ST_RELEASE
    } seq_state_e;

endpackage

// File: rtl/fwr_cfg_regs.sv
module fwr_cfg_regs
    import fwr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CFG_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    output setup_t             setup_q [NUM_CS],
    output logic               mm_owner
);

    // One setup word per chip select at consecutive word indices.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                setup_q[g] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(g)) begin
                setup_q[g] <= setup_t'(cfg_wdata);
            end
        end
    end

    // Ownership switch sits right after the setup words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mm_owner <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(NUM_CS)) begin
            mm_owner <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/fwr_sequencer.sv
module fwr_sequencer
    import fwr_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int MAX_BYTES = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int DATA_W   = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mm_owner,
    input  setup_t            setup_q [NUM_CS],
    input  logic              rd_req,
    input  logic [CS_W-1:0]   rd_cs,
    input  logic [31:0]       rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              rd_busy,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              sq_sclk,
    output logic [NUM_CS-1:0] sq_cs_n,
    output logic [3:0]        sq_io_out,
    output logic [3:0]        sq_io_oe,
    input  logic [3:0]        sq_io_in
);

    localparam int CNT_W = $clog2(8 * MAX_BYTES + 64);
    localparam int TX_W  = 40;

    seq_state_e         state;
    seq_state_e         phase_next;
    setup_t             cur;
    setup_t             sel;
    logic [CS_W-1:0]    cur_cs;
    logic [LEN_W-1:0]   len_q;
    logic [TX_W-1:0]    tx_sr;
    logic [DATA_W-1:0]  rx_sr;
    logic [DATA_W-1:0]  rx_shifted;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   phase_len;
    logic [CNT_W-1:0]   data_sclks;
    logic [31:0]        addr_al;
    logic               sclk_q;
    logic               req_ok;
    int                 wshift;

    // Request qualification and launch values.
    always_comb begin
        sel     = setup_q[rd_cs];
        req_ok  = mm_owner && (rd_len != '0) && (int'(rd_len) <= MAX_BYTES);
        addr_al = rd_addr << {~sel.addr_m1, 3'b000};
    end

    // Lane width of the active read, and capture shift.
    always_comb begin
        unique case (cur.mode)
            LANES_2: begin
                wshift     = 1;
                rx_shifted = {rx_sr[DATA_W-3:0], sq_io_in[1:0]};
            end
            LANES_4: begin
                wshift     = 2;
                rx_shifted = {rx_sr[DATA_W-5:0], sq_io_in[3:0]};
            end
            default: begin
                wshift     = 0;
                rx_shifted = {rx_sr[DATA_W-2:0], sq_io_in[1]};
            end
        endcase
        data_sclks = CNT_W'((int'(len_q) * 8) >> wshift);
    end

    // Following phase and its length in SCLK periods.
    always_comb begin
        phase_next = ST_IDLE;
        phase_len  = '0;
        unique case (state)
            ST_OPCODE: begin
                phase_next = ST_ADDRESS;
                phase_len  = CNT_W'((int'(cur.addr_m1) + 1) * 8);
            end
            ST_ADDRESS: begin
                if (cur.dummy != 2'd0) begin
                    phase_next = ST_DUMMY;
                    phase_len  = CNT_W'(int'(cur.dummy) * 8);
                end else begin
                    phase_next = ST_DATA;
                    phase_len  = data_sclks;
                end
            end
            ST_DUMMY: begin
                phase_next = ST_DATA;
                phase_len  = data_sclks;
            end
            ST_DATA: begin
                phase_next = ST_RELEASE;
                phase_len  = '0;
            end
            default: begin
                phase_next = ST_IDLE;
                phase_len  = '0;
            end
        endcase
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur    <= '0;
            cur_cs <= '0;
            len_q  <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rd_req) begin
                        if (req_ok) begin
                            state  <= ST_SELECT;
                            cur    <= sel;
                            cur_cs <= rd_cs;
                            len_q  <= rd_len;
                            tx_sr  <= {sel.opcode, addr_al};
                            rx_sr  <= '0;
                        end else begin
                            state <= ST_REFUSE;
                        end
                    end
                end
                ST_REFUSE: state <= ST_IDLE;
                ST_SELECT: begin
                    state  <= ST_OPCODE;
                    cnt    <= CNT_W'(8);
                    sclk_q <= 1'b0;
                end
                ST_OPCODE, ST_ADDRESS, ST_DUMMY, ST_DATA: begin
                    sclk_q <= ~sclk_q;
                    if (sclk_q) begin
                        tx_sr <= tx_sr << 1;
                        if (state == ST_DATA) begin
                            rx_sr <= rx_shifted;
                        end
                        if (cnt == CNT_W'(1)) begin
                            state <= phase_next;
                            cnt   <= phase_len;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                ST_RELEASE: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        rd_busy   = (state != ST_IDLE);
        rd_valid  = (state == ST_RELEASE);
        rd_err    = (state == ST_REFUSE);
        sq_sclk   = sclk_q;
        sq_cs_n   = '1;
        sq_io_out = {3'b000, tx_sr[TX_W-1]};
        sq_io_oe  = 4'b0000;
        unique case (state)
            ST_SELECT, ST_OPCODE, ST_ADDRESS: begin
                sq_cs_n[cur_cs] = 1'b0;
                sq_io_oe        = 4'b0001;
            end
            ST_DUMMY, ST_DATA: sq_cs_n[cur_cs] = 1'b0;
            default: ;
        endcase
        rd_data = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k < int'(len_q)) begin
                rd_data[8*k +: 8] = rx_sr[8*(int'(len_q) - 1 - k) +: 8];
            end
        end
    end

endmodule

// File: rtl/fwr_pin_mux.sv
module fwr_pin_mux #(
    parameter int NUM_CS = 4
) (
    input  logic              mm_owner,
    input  logic              sq_sclk,
    input  logic [NUM_CS-1:0] sq_cs_n,
    input  logic [3:0]        sq_io_out,
    input  logic [3:0]        sq_io_oe,
    input  logic              cmd_sclk,
    input  logic [NUM_CS-1:0] cmd_cs_n,
    input  logic [3:0]        cmd_io_out,
    input  logic [3:0]        cmd_io_oe,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe
);

    always_comb begin
        if (mm_owner) begin
            spi_sclk   = sq_sclk;
            spi_cs_n   = sq_cs_n;
            spi_io_out = sq_io_out;
            spi_io_oe  = sq_io_oe;
        end else begin
            spi_sclk   = cmd_sclk;
            spi_cs_n   = cmd_cs_n;
            spi_io_out = cmd_io_out;
            spi_io_oe  = cmd_io_oe;
        end
    end

endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
    import fwr_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int MAX_BYTES = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int CFG_AW   = $clog2(NUM_CS + 1),
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int DATA_W   = 8 * MAX_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic               rd_req,
    input  logic [CS_W-1:0]    rd_cs,
    input  logic [31:0]        rd_addr,
    input  logic [LEN_W-1:0]   rd_len,
    output logic               rd_busy,
    output logic               rd_valid,
    output logic               rd_err,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               cmd_sclk,
    input  logic [NUM_CS-1:0]  cmd_cs_n,
    input  logic [3:0]         cmd_io_out,
    input  logic [3:0]         cmd_io_oe,
    output logic               spi_sclk,
    output logic [NUM_CS-1:0]  spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in
);

    setup_t            setup_q [NUM_CS];
    logic              mm_owner;
    logic              seq_sclk;
    logic [NUM_CS-1:0] seq_cs_n;
    logic [3:0]        seq_io_out;
    logic [3:0]        seq_io_oe;

    fwr_cfg_regs #(
        .NUM_CS (NUM_CS),
        .CFG_AW (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .setup_q   (setup_q),
        .mm_owner  (mm_owner)
    );

    fwr_sequencer #(
        .NUM_CS    (NUM_CS),
        .MAX_BYTES (MAX_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mm_owner  (mm_owner),
        .setup_q   (setup_q),
        .rd_req    (rd_req),
        .rd_cs     (rd_cs),
        .rd_addr   (rd_addr),
        .rd_len    (rd_len),
        .rd_busy   (rd_busy),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err),
        .rd_data   (rd_data),
        .sq_sclk   (seq_sclk),
        .sq_cs_n   (seq_cs_n),
        .sq_io_out (seq_io_out),
        .sq_io_oe  (seq_io_oe),
        .sq_io_in  (spi_io_in)
    );

    fwr_pin_mux #(
        .NUM_CS (NUM_CS)
    ) u_mux (
        .mm_owner   (mm_owner),
        .sq_sclk    (seq_sclk),
        .sq_cs_n    (seq_cs_n),
        .sq_io_out  (seq_io_out),
        .sq_io_oe   (seq_io_oe),
        .cmd_sclk   (cmd_sclk),
        .cmd_cs_n   (cmd_cs_n),
        .cmd_io_out (cmd_io_out),
        .cmd_io_oe  (cmd_io_oe),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe)
    );

endmodule

// File: rtl/fwr_checker.sv
module fwr_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_busy,
    input logic              rd_valid,
    input logic              rd_err,
    input logic              seq_sclk,
    input logic [NUM_CS-1:0] seq_cs_n
);

    assert_cs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~seq_cs_n));

    assert_sclk_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_sclk) |=> $fell(seq_sclk));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> (&seq_cs_n && !seq_sclk));

    assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_req));

    assert_err_noselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> &seq_cs_n);

    assert_valid_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_err));

    assert_valid_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_busy);

endmodule

bind flash_window_reader fwr_checker #(.NUM_CS(NUM_CS)) u_fwr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_busy  (rd_busy),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .seq_sclk (seq_sclk),
    .seq_cs_n (seq_cs_n)
);

// File: tb/flash_window_reader_test.sv
module flash_window_reader_test;

    localparam int NUM_CS    = 4;
    localparam int MAX_BYTES = 4;
    localparam int CS_W      = 2;
    localparam int CFG_AW    = 3;
    localparam int LEN_W     = 3;
    localparam int DATA_W    = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [CFG_AW-1:0]  cfg_addr = '0;
    logic [13:0]        cfg_wdata = '0;
    logic               rd_req = 1'b0;
    logic [CS_W-1:0]    rd_cs = '0;
    logic [31:0]        rd_addr = '0;
    logic [LEN_W-1:0]   rd_len = '0;
    logic               rd_busy, rd_valid, rd_err;
    logic [DATA_W-1:0]  rd_data;
    logic               cmd_sclk = 1'b0;
    logic [NUM_CS-1:0]  cmd_cs_n = '1;
    logic [3:0]         cmd_io_out = '0;
    logic [3:0]         cmd_io_oe = '0;
    logic               spi_sclk;
    logic [NUM_CS-1:0]  spi_cs_n;
    logic [3:0]         spi_io_out, spi_io_oe;
    logic [3:0]         spi_io_in = '0;

    flash_window_reader #(.NUM_CS(NUM_CS), .MAX_BYTES(MAX_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_cs(rd_cs),
        .rd_addr(rd_addr), .rd_len(rd_len), .rd_busy(rd_busy),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out),
        .cmd_io_oe(cmd_io_oe), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    int checks = 0;
    int errors = 0;

    // Bench copy of the configuration it wrote.
    int cfg_op [NUM_CS];
    int cfg_ab [NUM_CS];
    int cfg_dm [NUM_CS];
    int cfg_md [NUM_CS];

    // Flash model state.
    int          rises = 0;
    int          cmd_bits = 8;
    int          pre_bits = 1000;
    int          lanes = 1;
    logic [7:0]  base_byte = '0;
    logic [63:0] mosi_log = '0;
    bit          oe_bad = 1'b0;

    function automatic logic [7:0] fbyte(logic [7:0] b, int k);
        return b + 8'(k * 37);
    endfunction

    function automatic bit stream_bit(logic [7:0] b, int s);
        logic [7:0] v;
        if (s / 8 >= MAX_BYTES) return 1'b0;
        v = fbyte(b, s / 8);
        return v[7 - (s % 8)];
    endfunction

    function automatic int lanes_of(int mode);
        return (mode == 1) ? 2 : (mode == 3) ? 4 : 1;
    endfunction

    always @(posedge spi_sclk) begin
        if (rises < cmd_bits) mosi_log = {mosi_log[62:0], spi_io_out[0]};
        else if (spi_io_oe != 4'b0000) oe_bad = 1'b1;
        rises = rises + 1;
    end

    always @(negedge spi_sclk) begin
        int c;
        logic [3:0] v;
        if (rises >= pre_bits) begin
            c = rises - pre_bits;
            v = '0;
            for (int j = 0; j < lanes; j++) v[lanes - 1 - j] = stream_bit(base_byte, c * lanes + j);
            if (lanes == 1) spi_io_in = {2'b00, v[0], 1'b0};
            else spi_io_in = v;
        end
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(int addr, logic [13:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CFG_AW'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_setup(int cs, int op, int ab, int dm, int md);
        cfg_op[cs] = op; cfg_ab[cs] = ab; cfg_dm[cs] = dm; cfg_md[cs] = md;
        wr_cfg(cs, {2'(md), 2'(dm), 2'(ab - 1), 8'(op)});
    endtask

    task automatic do_read(int cs, logic [31:0] addr, int len, bit expect_ok, bit poke);
        int n;
        logic [NUM_CS-1:0] cs_obs;
        logic [63:0] exp_mosi;
        logic [DATA_W-1:0] exp_data;
        int total;
        lanes     = lanes_of(cfg_md[cs]);
        cmd_bits  = 8 + 8 * cfg_ab[cs];
        pre_bits  = cmd_bits + 8 * cfg_dm[cs];
        base_byte = addr[7:0] ^ 8'h5A;
        rises = 0; mosi_log = '0; oe_bad = 1'b0; cs_obs = '1;
        @(negedge clk);
        rd_req = 1'b1; rd_cs = CS_W'(cs); rd_addr = addr; rd_len = LEN_W'(len);
        @(negedge clk);
        rd_req = 1'b0;
        if (!expect_ok) begin
            check(rd_err == 1'b1, "R3", "refusal pulse", 64'(rd_err), 64'd1);
            check(spi_cs_n == '1, "R3", "no select on refusal", 64'(spi_cs_n), 64'hF);
            @(negedge clk);
            check(rd_err == 1'b0 && rises == 0, "R3", "refusal one cycle", 64'(rd_err), 64'd0);
            return;
        end
        check(rd_busy == 1'b1 && rd_err == 1'b0, "R8", "busy after accept", 64'(rd_busy), 64'd1);
        n = 0;
        while (!rd_valid && n < 2000) begin
            if (spi_cs_n != '1) cs_obs = spi_cs_n;
            if (poke && n == 6) begin
                rd_req = 1'b1; rd_cs = CS_W'(cs + 1); rd_addr = ~addr; rd_len = LEN_W'(1);
            end
            if (poke && n == 7) rd_req = 1'b0;
            @(negedge clk);
            n++;
        end
        check(rd_valid == 1'b1, "R8", "completion before watchdog", 64'(rd_valid), 64'd1);
        exp_mosi = 64'(cfg_op[cs]);
        for (int b = cfg_ab[cs] - 1; b >= 0; b--) exp_mosi = (exp_mosi << 8) | 64'(addr[8*b +: 8]);
        exp_data = '0;
        for (int k = 0; k < len; k++) exp_data[8*k +: 8] = fbyte(base_byte, k);
        total = pre_bits + (8 * len) / lanes;
        check(spi_cs_n == '1, "R8", "select high at valid", 64'(spi_cs_n), 64'hF);
        check(cs_obs == ~(NUM_CS'(1) << cs), "R4", "only addressed select low", 64'(cs_obs), 64'(~(NUM_CS'(1) << cs)));
        check(mosi_log == exp_mosi, "R1 R10", "opcode and address bits", mosi_log, exp_mosi);
        check(rises == total, "R5", "SCLK edge count", 64'(rises), 64'(total));
        check(!oe_bad, "R5", "no drive in dummy or data", 64'(oe_bad), 64'd0);
        check(rd_data == exp_data, poke ? "R9" : "R6 R7", "returned bytes", 64'(rd_data), 64'(exp_data));
        @(negedge clk);
        check(!rd_valid && !rd_busy, "R8", "valid single cycle then idle", 64'({rd_valid, rd_busy}), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < NUM_CS; i++) begin
            cfg_op[i] = 0; cfg_ab[i] = 1; cfg_dm[i] = 0; cfg_md[i] = 0;
        end
        cmd_cs_n = 4'b1010; cmd_sclk = 1'b1; cmd_io_out = 4'h5; cmd_io_oe = 4'h3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_busy && !rd_valid && !rd_err, "R8", "reset idle", 64'({rd_busy, rd_valid, rd_err}), 64'd0);
        check(spi_sclk == 1'b1 && spi_cs_n == 4'b1010 && spi_io_out == 4'h5 && spi_io_oe == 4'h3,
              "R2", "pass-through at reset", 64'({spi_sclk, spi_cs_n, spi_io_out, spi_io_oe}), 64'h1A53);
        cmd_sclk = 1'b0; cmd_cs_n = '1;
        // Switch still 0: refused.
        do_read(0, 32'h100, 2, 1'b0, 1'b0);
        wr_cfg(NUM_CS, 14'h1);
        cmd_cs_n = 4'b0000; cmd_sclk = 1'b1; cmd_io_oe = 4'hF;
        @(negedge clk);
        check(spi_sclk == 1'b0 && spi_cs_n == '1 && spi_io_oe == 4'h0, "R2", "read path owns idle pins",
              64'({spi_sclk, spi_cs_n, spi_io_oe}), 64'h1E0 >> 1);
        cmd_cs_n = '1; cmd_sclk = 1'b0; cmd_io_oe = 4'h0;
        // Directed corners.
        set_setup(0, 8'h03, 3, 0, 0);
        do_read(0, 32'hFF12_3456, 4, 1'b1, 1'b0);
        set_setup(1, 8'h3B, 3, 1, 1);
        do_read(1, 32'h0000_0A0B, 3, 1'b1, 1'b0);
        set_setup(2, 8'h6B, 4, 1, 3);
        do_read(2, 32'h89AB_CDEF, 1, 1'b1, 1'b0);
        set_setup(3, 8'hA5, 1, 2, 2);
        do_read(3, 32'h0000_0077, 2, 1'b1, 1'b0);
        do_read(1, 32'h40, 0, 1'b0, 1'b0);
        do_read(1, 32'h40, 5, 1'b0, 1'b0);
        do_read(2, 32'h1234_5678, 4, 1'b1, 1'b1);
        // Random reads.
        for (int it = 0; it < 40; it++) begin
            int cs, md;
            cs = int'($urandom_range(NUM_CS - 1, 0));
            if ($urandom_range(2, 0) == 0) begin
                md = int'($urandom_range(3, 0));
                set_setup(cs, int'($urandom_range(255, 0)), int'($urandom_range(4, 1)),
                          int'($urandom_range(3, 0)), md);
            end
            do_read(cs, $urandom, int'($urandom_range(MAX_BYTES, 1)), 1'b1, 1'b0);
        end
        // Hand pins back.
        wr_cfg(NUM_CS, 14'h0);
        cmd_cs_n = 4'b0110; cmd_io_out = 4'hA; cmd_io_oe = 4'h9;
        @(negedge clk);
        check(spi_cs_n == 4'b0110 && spi_io_out == 4'hA && spi_io_oe == 4'h9, "R2", "pins returned",
              64'({spi_cs_n, spi_io_out, spi_io_oe}), 64'h6A9);
        cmd_cs_n = '1; cmd_io_oe = 4'h0;
        do_read(0, 32'h10, 1, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule